// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a clocked model of a 256-byte serial EEPROM that answers on a two-wire bus. It oversamples the clock and data lines with the system clock, finds START and STOP conditions, and checks the 8-bit selector byte against a fixed 4-bit identity and three strap inputs. It takes one word-address byte and then either stores data or streams data back out. The SDA output is open-drain: the block only requests that the line be pulled low.

Writes go into a one-page staging buffer first. They reach the array only when a STOP closes a transaction that carried at least one complete data byte, and only if the protect input is low at that moment. Each stored write starts a busy window, a parameter in system clock cycles. During that window the block refuses its selector byte, so a host finds out that the write has finished by polling. Reads fetch from the word pointer and advance it over the whole array.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The selector byte is acknowledged, by asserting `sda_oe_o` in the ninth clock, only when its upper seven bits equal 1010 followed by `strap_i[2:0]`. Bit 0 is 0 for a write and 1 for a read. After a mismatch the block acknowledges nothing until the next START.
- R2: A write (selector, word address, data) stores its data in the array when STOP follows at least one complete data byte. Every byte received is acknowledged.
- R3: Within a write, the pointer advances only in its low 5 bits and stays inside the 32-byte page. Data bytes beyond 32 replace the earliest bytes of that page, and the last byte received at an offset wins.
- R4: If `wp_i` is high at STOP, the array is unchanged and no busy window starts.
- R5: A write ended by a repeated START, or by STOP before a full data byte, changes nothing and starts no busy window. A word address alone still loads the pointer.
- R6: For `WR_CYCLES` clock cycles after a storing STOP, the selector byte is not acknowledged. After that it is acknowledged again.
- R7: A read after the word-address phase (repeated START, selector with bit 0 = 1) returns the byte at that address. Each host acknowledge fetches the next byte, and the pointer wraps from 255 to 0.
- R8: A read without a word address starts at the pointer. After a read the pointer is one past the last byte sent. After a write it is the in-page successor of the last byte written.
- R9: A host NACK after a read byte ends the transfer. The block drives nothing further until the next START.
- R10: During and after reset, SDA is released, the array reads as zero and no busy window is active.
- R11: `sda_oe_o` only turns on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 requests that SDA be pulled low |
| strap_i | input | 3 | Strap bits compared with selector bits 3:1 |
| wp_i | input | 1 | Write protect, sampled at STOP |

## Verification
The hardest state to reach is the page-wrap merge. The bench writes 36 bytes starting near the end of a page, so four bytes wrap around and overwrite buffered ones before the single commit. It then reads 33 bytes in sequence to see the whole page and the first byte of the next page unchanged. The busy window is checked by sending a selector immediately after a storing STOP and expecting a NACK, then polling until an acknowledge returns. Abort paths (repeated START after data, STOP in the middle of a byte, protect high) are each followed at once by a poll that must be acknowledged and by a read-back.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_RDATA} tgt_st_e;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LINES = 2;
  logic [LINES-1:0] raw, meta_q, sync_q, dly_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b1;
        sync_q[g] <= 1'b1;
        dly_q[g]  <= 1'b1;
      end else begin
        meta_q[g] <= raw[g];
        sync_q[g] <= meta_q[g];
        dly_q[g]  <= sync_q[g];
      end
    end
  end

  assign scl_o      = sync_q[1];
  assign sda_o      = sync_q[0];
  assign scl_rise_o = sync_q[1] & ~dly_q[1];
  assign scl_fall_o = ~sync_q[1] & dly_q[1];
  assign start_o    = sync_q[1] & dly_q[1] & dly_q[0] & ~sync_q[0];
  assign stop_o     = sync_q[1] & dly_q[1] & ~dly_q[0] & sync_q[0];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
  parameter int unsigned WR_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R6
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAGE = 1 << PAGE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  logic [PAGE_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [PAGE-1:0]               mask_o,
  output logic [PAGE-1:0][DATA_W-1:0]   data_o
);
  logic [PAGE-1:0]             mask_q;
  logic [PAGE-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      data_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q[idx_i] <= 1'b1;
      data_q[idx_i] <= data_i;
    end
  end

  assign mask_o = mask_q;
  assign data_o = data_q;

  AST_BUF_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> mask_q[$past(idx_i)]); // R3
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAGE  = 1 << PAGE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned PG_W  = ADDR_W - PAGE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        commit_i,
  input  logic [PG_W-1:0]             page_i,
  input  logic [PAGE-1:0]             mask_i,
  input  logic [PAGE-1:0][DATA_W-1:0] buf_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    localparam int unsigned OFF = a % PAGE;
    localparam logic [PG_W-1:0] PG = PG_W'(a / PAGE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[a] <= '0;
      else if (commit_i && page_i == PG && mask_i[OFF]) mem_q[a] <= buf_i[OFF];
    end

    AST_ARRAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(mem_q[a])); // R5
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PAGE_W    = 5,
  parameter int unsigned STRAP_W   = 3,
  parameter int unsigned DEV_ID    = 10,
  parameter int unsigned WR_CYCLES = 1000000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_i
);
  localparam int unsigned PAGE = 1 << PAGE_W;
  localparam int unsigned ID_W = 7 - STRAP_W;
  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;
  logic [BYTE_W-1:0] rd_data;
  logic [PAGE-1:0] buf_mask;
  logic [PAGE-1:0][BYTE_W-1:0] buf_data;

  tgt_st_e st_q;
  logic [3:0] cnt_q;
  logic in_ack_q, oe_q, rw_q, mack_q, wr_pend_q;
  logic [BYTE_W-1:0] shreg_q, tx_q;
  logic [ADDR_W-1:0] ptr_q;

  logic rx_state, bus_evt, ack_begin, ack_end, addr_hit, buf_wr, commit, rd_load;
  logic [ADDR_W-1:0] ptr_page_inc;

  eeprom_bus_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eeprom_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  eeprom_page_buf #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(start_det), .wr_i(buf_wr), .idx_i(ptr_q[PAGE_W-1:0]),
    .data_i(shreg_q), .mask_o(buf_mask), .data_o(buf_data)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(BYTE_W)) u_array (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(ptr_q[ADDR_W-1:PAGE_W]),
    .mask_i(buf_mask), .buf_i(buf_data), .rd_addr_i(ptr_q), .rd_data_o(rd_data)
  );

  always_comb begin
    rx_state     = (st_q == ST_DEV) || (st_q == ST_WADDR) || (st_q == ST_WDATA);
    bus_evt      = start_det | stop_det;
    ack_begin    = !bus_evt && rx_state && scl_fall && (cnt_q == 4'd8) && !in_ack_q;
    ack_end      = !bus_evt && rx_state && scl_fall && in_ack_q;
    addr_hit     = (shreg_q[7:1] == {ID_W'(DEV_ID), strap_i});
    buf_wr       = ack_begin && (st_q == ST_WDATA);
    commit       = stop_det && wr_pend_q && !wp_i;
    rd_load      = !bus_evt &&
                   ((ack_end && st_q == ST_DEV && rw_q) ||
                    (st_q == ST_RDATA && scl_fall && cnt_q == 4'd8 && !mack_q));
    ptr_page_inc = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      wr_pend_q <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
    end else if (bus_evt) begin
      st_q      <= start_det ? ST_DEV : ST_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      oe_q      <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      if (rx_state && scl_rise && cnt_q < 4'd8) begin
        shreg_q <= {shreg_q[6:0], sda_s};
        cnt_q   <= cnt_q + 1'b1;
      end
      if (ack_begin) begin
        if (st_q == ST_DEV) begin
          if (addr_hit && !busy) begin
            oe_q     <= 1'b1;
            in_ack_q <= 1'b1;
            rw_q     <= shreg_q[0];
          end else begin
            st_q <= ST_IDLE;
          end
        end else begin
          oe_q     <= 1'b1;
          in_ack_q <= 1'b1;
          if (st_q == ST_WADDR) begin
            ptr_q <= shreg_q[ADDR_W-1:0];
          end else begin
            ptr_q     <= ptr_page_inc;
            wr_pend_q <= 1'b1;
          end
        end
      end
      if (ack_end) begin
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
        cnt_q    <= '0;
        if (st_q == ST_DEV) st_q <= rw_q ? ST_RDATA : ST_WADDR;
        else                st_q <= ST_WDATA;
      end
      if (st_q == ST_RDATA) begin
        if (scl_rise && cnt_q == 4'd8) mack_q <= sda_s;
        if (scl_fall) begin
          if (cnt_q < 4'd7) begin
            cnt_q <= cnt_q + 1'b1;
            tx_q  <= {tx_q[6:0], 1'b0};
            oe_q  <= !tx_q[6];
          end else if (cnt_q == 4'd7) begin
            cnt_q <= 4'd8;
            oe_q  <= 1'b0;
          end else if (mack_q) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
          end
        end
      end
      // fetch overrides the release above
      if (rd_load) begin
        tx_q  <= rd_data;
        oe_q  <= !rd_data[7];
        ptr_q <= ptr_q + 1'b1;
        cnt_q <= '0;
      end
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_s); // R11
  AST_READ_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load |=> ptr_q == $past(ptr_q) + 1'b1); // R7
  AST_WRITE_PTR_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])); // R3
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEV && in_ack_q) |-> !busy); // R6
  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !oe_q); // R9
endmodule

// File: tb/sim_eeprom_i2c_target.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_target;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int WRC = 1000;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = m_sda & ~sda_oe;

  eeprom_i2c_target #(.WR_CYCLES(WRC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mref [256];
  logic [7:0] wbuf [64];
  logic [7:0] mptr = 8'h00;

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1; w(Q); m_scl = 1; w(2*Q); m_sda = 0; w(2*Q); m_scl = 0; w(Q);
  endtask
  task automatic bus_stop();
    m_sda = 0; w(Q); m_scl = 1; w(2*Q); m_sda = 1; w(2*Q);
  endtask
  task automatic bit_out(input logic b);
    m_sda = b; w(Q); m_scl = 1; w(2*Q); m_scl = 0; w(Q);
  endtask
  task automatic bit_in(output logic b);
    m_sda = 1; w(Q); m_scl = 1; w(Q); b = sda_line; w(Q); m_scl = 0; w(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask
  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(nack);
  endtask

  task automatic do_write(input logic [7:0] wa, input int n);
    logic ack; bit all_ack = 1;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack); all_ack &= ack;
    send_byte(wa, ack); all_ack &= ack;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], ack); all_ack &= ack; end
    bus_stop();
    chk("R2 write bytes acked", int'(all_ack), 1);
    for (int i = 0; i < n; i++)
      if (!wp) mref[{wa[7:5], 5'(wa[4:0] + i)}] = wbuf[i];
    mptr = {wa[7:5], 5'(wa[4:0] + n)};
  endtask

  task automatic poll(output logic ack);
    bus_start(); send_byte({4'b1010, STRAP, 1'b0}, ack); bus_stop();
  endtask

  task automatic wait_ready();
    logic ack = 0;
    for (int i = 0; i < 20 && !ack; i++) poll(ack);
    chk("R6 ready after write cycle", int'(ack), 1);
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n, input string tag);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(wa, ack);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(tag, int'(d), int'(mref[8'(wa + i)]));
    end
    bus_stop();
    mptr = 8'(wa + n);
  endtask

  task automatic cur_read(input string tag);
    logic ack; logic [7:0] d;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    recv_byte(1'b1, d);
    bus_stop();
    chk(tag, int'(d), int'(mref[mptr]));
    mptr = mptr + 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, b;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) mref[i] = 8'h00;
    w(5);
    chk("R10 sda released in reset", int'(sda_oe), 0);
    rst_n = 1; w(10);
    chk("R10 sda released after reset", int'(sda_oe), 0);
    poll(ack);
    chk("R10 not busy after reset", int'(ack), 1);
    rand_read(8'h80, 1, "R10 array cleared");

    // strap sweep
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk("R1 strap match", int'(ack), int'(3'(s) == STRAP));
      if (!ack) begin
        send_byte(8'h00, ack);
        chk("R1 ignored after mismatch", int'(ack), 0);
      end
      bus_stop();
    end
    for (int n = 0; n < 16; n++) begin
      if (n == 10) continue;
      bus_start();
      send_byte({4'(n), STRAP, 1'b0}, ack);
      chk("R1 identity mismatch", int'(ack), 0);
      bus_stop();
    end

    // byte write and busy polling
    wbuf[0] = 8'hA5;
    do_write(8'h10, 1);
    poll(ack);
    chk("R6 nack while busy", int'(ack), 0);
    wait_ready();
    rand_read(8'h10, 1, "R2 byte stored");

    // page write with wrap
    for (int i = 0; i < 36; i++) wbuf[i] = 8'(i * 7 + 3);
    do_write(8'h3C, 36);
    wait_ready();
    rand_read(8'h20, 33, "R3 page wrap");
    cur_read("R8 current after read");

    // pointer after write wraps in page
    wbuf[0] = 8'hC3;
    do_write(8'h40, 1);
    wait_ready();
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    do_write(8'h5E, 2);
    wait_ready();
    cur_read("R8 current after write");

    // write protect
    wp = 1;
    wbuf[0] = 8'h77;
    do_write(8'h10, 1);
    poll(ack);
    chk("R4 no busy when protected", int'(ack), 1);
    wp = 0;
    rand_read(8'h10, 1, "R4 array unchanged");

    // abort by repeated start
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h11, ack);
    send_byte(8'h33, ack);
    bus_start();
    bus_stop();
    poll(ack);
    chk("R5 no busy after restart abort", int'(ack), 1);
    rand_read(8'h11, 1, "R5 restart abort unchanged");

    // abort mid-byte
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h12, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    poll(ack);
    chk("R5 no busy after partial byte", int'(ack), 1);
    rand_read(8'h12, 1, "R5 partial byte unchanged");

    // sequential read across top of array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(8'hFE, 2);
    wait_ready();
    wbuf[0] = 8'h99;
    do_write(8'h00, 1);
    wait_ready();
    rand_read(8'hFD, 5, "R7 wrap 255 to 0");

    // NACK ends read
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    send_byte(8'h20, ack);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk("R7 first streamed byte", int'(d), int'(mref[8'h20]));
    recv_byte(1'b1, d);
    chk("R7 second streamed byte", int'(d), int'(mref[8'h21]));
    bit_in(b);
    chk("R9 line released after nack", int'(b), 1);
    chk("R9 no drive after nack", int'(sda_oe), 0);
    bus_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule